// File: doc/BRIEF.md
# Instruction Line Fill and Next-Line Prefetch Engine

This block sits between an instruction fetch unit and a burst-capable memory. It fetches 128-bit instruction cache lines over a 32-bit data path. A request goes out as a single-cycle pulse carrying a line-aligned byte address. The memory answers with four beats, one per clock, in ascending address order. The block gathers the beats into a full line and hands it to the cache in a single-cycle fill pulse. The pulse carries the line address and a flag that says whether the line came from a demand fetch or a prefetch.

The fetch unit raises a demand miss when it needs a line that is not cached. It also reports each time execution moves into a new line, together with whether that line was already resident. If the line was just brought in from memory, the block asks for the sequentially following line. If the line was already resident, the block asks for nothing, on the assumption that the code is looping back. Only one burst is in flight at a time.

A demand miss that arrives during a burst is held in a one-entry slot and issued after the burst. A held miss is not issued when the burst in flight already covers the missing line, because that line is about to arrive anyway. A prefetch trigger that cannot start at once is discarded.

Top module: `ifetch_line_prefetch`

## Requirements
- R1: After synchronous reset, `mem_req` and `fill_valid` are low and stay low until a miss or a prefetch trigger arrives.
- R2: A demand miss accepted while the block is idle produces `mem_req` high for exactly one cycle, in the cycle after the miss. `mem_addr` holds the miss address with bits [3:0] cleared.
- R3: The four beats of a burst are placed in arrival order, the first in `fill_data[31:0]` and the last in `fill_data[127:96]`. `fill_valid` is high for exactly one cycle, in the cycle after the fourth beat is sampled. In that cycle `fill_addr` equals the requested address, and `fill_is_prefetch` is 0 for a demand burst and 1 for a prefetch burst.
- R4: While idle, with no miss present, `exec_valid` high with `exec_was_hit`=0 issues a prefetch in the next cycle. Its address is the executing line's aligned address plus 16.
- R5: `exec_valid` high with `exec_was_hit`=1 issues no memory request.
- R6: The prefetch address wraps modulo 2^32, so the line at 0xFFFF_FFF0 is followed by the line at 0x0000_0000.
- R7: A demand miss for a different line that arrives while a burst is in flight raises no request during that burst. It is requested in the cycle after the fill pulse of that burst, and its fill carries `fill_is_prefetch`=0.
- R8: A demand miss whose line equals the line of the burst in flight raises no further request. That line is filled exactly once.
- R9: A prefetch trigger is dropped if a burst is in flight, if a demand miss is waiting, or if a demand miss arrives in the same cycle. A demand miss takes priority in that last case.
- R10: At most one burst is outstanding. `mem_req` never rises between a request and the fill pulse that completes it.
- R11: `mem_rvalid` beats that arrive while no burst is outstanding are ignored. They cause no fill and do not disturb the data of the next burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| miss_valid | input | 1 | Demand miss pulse from the fetch unit |
| miss_addr | input | 32 | Byte address of the missing instruction |
| exec_valid | input | 1 | Pulse: execution has entered a new line |
| exec_line_addr | input | 32 | Address within the line now executing |
| exec_was_hit | input | 1 | 1 if that line was already resident, 0 if it was just filled |
| mem_req | output | 1 | Single-cycle burst request |
| mem_addr | output | 32 | Line-aligned burst address |
| mem_rvalid | input | 1 | Memory beat valid |
| mem_rdata | input | 32 | Memory beat data |
| fill_valid | output | 1 | Single-cycle line fill pulse to the cache |
| fill_addr | output | 32 | Line address of the fill |
| fill_data | output | 128 | Assembled line |
| fill_is_prefetch | output | 1 | 1 if the fill came from a prefetch burst |

## Verification
The hardest case to reach is a demand miss arriving while a prefetch burst is in flight, because the outcome depends on whether the missing line matches the prefetched one. The bench sets a memory latency of several cycles. It triggers a prefetch, then raises a miss a cycle or two later, once for a foreign line and once for the very line being prefetched. In a further run the memory latency is zero, and misses and triggers are placed at varying offsets, so that some land on the completion edge itself. Stray beats are also driven while the block is idle, ahead of a normal burst.

// File: rtl/ifp_pkg.sv
package ifp_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } ifp_state_t;

  typedef enum logic {
    K_DEMAND   = 1'b0,
    K_PREFETCH = 1'b1
  } ifp_kind_t;

endpackage

// File: rtl/ifp_next_line.sv
module ifp_next_line #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic [ADDR_W-1:0] line_addr,
  output logic [ADDR_W-1:0] next_addr
);

  logic unused_low;
  assign unused_low = ^line_addr[OFF_W-1:0];

  // Increment the line index; the carry out of the top bit is discarded.
  assign next_addr = {line_addr[ADDR_W-1:OFF_W] + 1'b1, {OFF_W{1'b0}}};

endmodule

// File: rtl/ifp_beat_asm.sv
module ifp_beat_asm #(
  parameter int BEAT_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clear,
  input  logic                    collect,
  input  logic                    beat_valid,
  input  logic [BEAT_W-1:0]       beat_data,
  output logic                    last,
  output logic [BEAT_W*BEATS-1:0] line_q
);

  localparam int LINE_W = BEAT_W * BEATS;
  localparam int CNT_W  = (BEATS > 1) ? $clog2(BEATS) : 1;

  logic [CNT_W-1:0]  cnt;
  logic              take;
  logic [LINE_W-1:0] line_next;

  assign take = collect && beat_valid;
  assign last = take && (cnt == CNT_W'(BEATS - 1));

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      cnt <= '0;
    end else if (take) begin
      cnt <= last ? '0 : cnt + 1'b1;
    end
  end

  // One storage slot per beat; the beat arriving this cycle bypasses its slot.
  for (genvar i = 0; i < BEATS; i++) begin : g_slot
    logic [BEAT_W-1:0] slot;
    always_ff @(posedge clk) begin
      if (take && cnt == CNT_W'(i)) begin
        slot <= beat_data;
      end
    end
    assign line_next[i*BEAT_W +: BEAT_W] =
      (take && cnt == CNT_W'(i)) ? beat_data : slot;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q <= '0;
    end else if (last) begin
      line_q <= line_next;
    end
  end

endmodule

// File: rtl/ifp_ctrl.sv
module ifp_ctrl
  import ifp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              miss_valid,
  input  logic [ADDR_W-1:0] miss_addr,
  input  logic              exec_valid,
  input  logic              exec_hit,
  input  logic [ADDR_W-1:0] next_addr,
  input  logic              burst_done,
  output logic              start,
  output logic              collect,
  output logic              busy,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              fill_valid,
  output logic [ADDR_W-1:0] fill_addr,
  output logic              fill_pref
);

  ifp_state_t        state;
  ifp_kind_t         cur_kind;
  ifp_kind_t         start_kind;
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] start_addr;
  logic [ADDR_W-1:0] miss_line;
  logic [ADDR_W-1:0] pend_addr;
  logic              pend_valid;
  logic              covers_miss;
  logic              unused_miss_low;

  assign miss_line       = {miss_addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
  assign unused_miss_low = ^miss_addr[OFF_W-1:0];
  assign covers_miss     = (miss_line == cur_addr);

  // Start selection when idle: held miss, then new miss, then prefetch.
  always_comb begin
    start      = 1'b0;
    start_addr = miss_line;
    start_kind = K_DEMAND;
    if (state == ST_IDLE) begin
      if (pend_valid) begin
        start      = 1'b1;
        start_addr = pend_addr;
      end else if (miss_valid) begin
        start      = 1'b1;
      end else if (exec_valid && !exec_hit) begin
        start      = 1'b1;
        start_addr = next_addr;
        start_kind = K_PREFETCH;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      cur_kind   <= K_DEMAND;
      cur_addr   <= '0;
      pend_valid <= 1'b0;
      pend_addr  <= '0;
      mem_req    <= 1'b0;
      mem_addr   <= '0;
      fill_valid <= 1'b0;
      fill_addr  <= '0;
      fill_pref  <= 1'b0;
    end else begin
      mem_req    <= start;
      fill_valid <= 1'b0;
      if (start) begin
        state    <= ST_WAIT;
        mem_addr <= start_addr;
        cur_addr <= start_addr;
        cur_kind <= start_kind;
      end
      if (state == ST_IDLE && pend_valid) begin
        pend_valid <= 1'b0;
      end
      if (state == ST_WAIT) begin
        if (miss_valid && !covers_miss) begin
          pend_valid <= 1'b1;
          pend_addr  <= miss_line;
        end
        if (burst_done) begin
          state      <= ST_IDLE;
          fill_valid <= 1'b1;
          fill_addr  <= cur_addr;
          fill_pref  <= (cur_kind == K_PREFETCH);
        end
      end
    end
  end

  assign collect = (state == ST_WAIT);
  assign busy    = (state != ST_IDLE) || pend_valid;

endmodule

// File: rtl/ifetch_line_prefetch.sv
module ifetch_line_prefetch #(
  parameter int ADDR_W = 32,
  parameter int BEAT_W = 32,
  parameter int BEATS  = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  input  logic                    exec_valid,
  input  logic [ADDR_W-1:0]       exec_line_addr,
  input  logic                    exec_was_hit,
  output logic                    mem_req,
  output logic [ADDR_W-1:0]       mem_addr,
  input  logic                    mem_rvalid,
  input  logic [BEAT_W-1:0]       mem_rdata,
  output logic                    fill_valid,
  output logic [ADDR_W-1:0]       fill_addr,
  output logic [BEAT_W*BEATS-1:0] fill_data,
  output logic                    fill_is_prefetch
);

  localparam int LINE_W = BEAT_W * BEATS;
  localparam int OFF_W  = $clog2(LINE_W / 8);

  logic [ADDR_W-1:0] nl_addr;
  logic              asm_last;
  logic              ctl_start;
  logic              ctl_collect;
  logic              ctl_busy;

  ifp_next_line #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_next (
    .line_addr (exec_line_addr),
    .next_addr (nl_addr)
  );

  ifp_ctrl #(
    .ADDR_W (ADDR_W),
    .OFF_W  (OFF_W)
  ) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .miss_valid (miss_valid),
    .miss_addr  (miss_addr),
    .exec_valid (exec_valid),
    .exec_hit   (exec_was_hit),
    .next_addr  (nl_addr),
    .burst_done (asm_last),
    .start      (ctl_start),
    .collect    (ctl_collect),
    .busy       (ctl_busy),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .fill_valid (fill_valid),
    .fill_addr  (fill_addr),
    .fill_pref  (fill_is_prefetch)
  );

  ifp_beat_asm #(
    .BEAT_W (BEAT_W),
    .BEATS  (BEATS)
  ) u_asm (
    .clk        (clk),
    .rst        (rst),
    .clear      (ctl_start),
    .collect    (ctl_collect),
    .beat_valid (mem_rvalid),
    .beat_data  (mem_rdata),
    .last       (asm_last),
    .line_q     (fill_data)
  );

endmodule

// File: rtl/ifp_checker.sv
module ifp_checker #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              exec_valid,
  input logic [ADDR_W-1:0] exec_line_addr,
  input logic              exec_was_hit,
  input logic              mem_req,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              fill_valid,
  input logic              busy
);

  localparam logic [ADDR_W-1:0] LINE_BYTES = ADDR_W'(1) << OFF_W;

  // Independent view of whether a burst is outstanding, built from ports only.
  logic outst;
  always_ff @(posedge clk) begin
    if (rst) begin
      outst <= 1'b0;
    end else if (mem_req) begin
      outst <= 1'b1;
    end else if (fill_valid) begin
      outst <= 1'b0;
    end
  end

  p_req_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |=> !mem_req);

  p_req_aligned_r2: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  p_fill_pulse_r3: assert property (@(posedge clk) disable iff (rst)
    fill_valid |=> !fill_valid);

  p_fill_has_req_r3: assert property (@(posedge clk) disable iff (rst)
    fill_valid |-> outst);

  p_pref_next_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy && exec_valid && !exec_was_hit && !miss_valid) |=>
      (mem_req && (mem_addr - {$past(exec_line_addr[ADDR_W-1:OFF_W]), {OFF_W{1'b0}}}) == LINE_BYTES));

  p_hit_quiet_r5: assert property (@(posedge clk) disable iff (rst)
    (!busy && exec_valid && exec_was_hit && !miss_valid) |=> !mem_req);

  p_one_burst_r10: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> !outst);

endmodule

bind ifetch_line_prefetch ifp_checker #(
  .ADDR_W (ADDR_W),
  .OFF_W  (OFF_W)
) u_chk (
  .clk            (clk),
  .rst            (rst),
  .miss_valid     (miss_valid),
  .exec_valid     (exec_valid),
  .exec_line_addr (exec_line_addr),
  .exec_was_hit   (exec_was_hit),
  .mem_req        (mem_req),
  .mem_addr       (mem_addr),
  .fill_valid     (fill_valid),
  .busy           (ctl_busy)
);

// File: tb/sim_ifetch_line_prefetch.sv
`timescale 1ns/1ps
module sim_ifetch_line_prefetch;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         miss_valid = 1'b0;
  logic [31:0]  miss_addr = '0;
  logic         exec_valid = 1'b0;
  logic [31:0]  exec_line_addr = '0;
  logic         exec_was_hit = 1'b0;
  logic         mem_req;
  logic [31:0]  mem_addr;
  logic         mem_rvalid = 1'b0;
  logic [31:0]  mem_rdata = '0;
  logic         fill_valid;
  logic [31:0]  fill_addr;
  logic [127:0] fill_data;
  logic         fill_is_prefetch;

  always #2.5 clk = ~clk;

  ifetch_line_prefetch u0 (
    .clk(clk), .rst(rst),
    .miss_valid(miss_valid), .miss_addr(miss_addr),
    .exec_valid(exec_valid), .exec_line_addr(exec_line_addr), .exec_was_hit(exec_was_hit),
    .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .fill_is_prefetch(fill_is_prefetch)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  int    n_req = 0;
  int    n_fill = 0;
  int    cyc = 0;
  string phase = "R1 reset";

  // ---------------- memory model ----------------
  int          mem_lat = 2;
  bit          stray_en = 1'b0;
  bit          srv = 1'b0;
  int          srv_wait = 0;
  int          srv_beat = 0;
  logic [31:0] srv_addr = '0;

  function automatic logic [31:0] beat_val(input logic [31:0] a, input int b);
    return (a + 32'(b * 4)) ^ 32'hC3A5_5A3C ^ (32'(b) << 28);
  endfunction

  always @(negedge clk) begin
    if (rst) begin
      srv = 1'b0;
      mem_rvalid = 1'b0;
    end else begin
      if (mem_req) begin
        srv = 1'b1; srv_addr = mem_addr; srv_wait = mem_lat; srv_beat = 0;
      end
      if (srv) begin
        if (srv_wait > 0) begin
          srv_wait--; mem_rvalid = 1'b0;
        end else begin
          mem_rvalid = 1'b1;
          mem_rdata  = beat_val(srv_addr, srv_beat);
          srv_beat++;
          if (srv_beat == 4) srv = 1'b0;
        end
      end else begin
        mem_rvalid = stray_en;
        mem_rdata  = 32'hDEAD_0000 | 32'(cyc);
      end
    end
  end

  // ---------------- reference model ----------------
  bit           m_burst, m_pend, m_pref;
  logic [31:0]  m_addr, m_pend_addr;
  logic [31:0]  bq[$];
  bit           e_req, e_fill, e_fpref;
  logic [31:0]  e_addr, e_faddr;
  logic [127:0] e_fdata;

  function automatic logic [31:0] al(input logic [31:0] a);
    return a & 32'hFFFF_FFF0;
  endfunction

  task automatic m_issue(input logic [31:0] a, input bit pf);
    m_burst = 1'b1; m_addr = a; m_pref = pf; bq.delete();
    e_req = 1'b1; e_addr = a;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_burst = 0; m_pend = 0; e_req = 0; e_fill = 0; bq.delete();
    end else begin
      e_req = 0; e_fill = 0;
      if (m_burst) begin
        if (mem_rvalid) begin
          bq.push_back(mem_rdata);
          if (bq.size() == 4) begin
            e_fill = 1; e_faddr = m_addr; e_fpref = m_pref;
            e_fdata = {bq[3], bq[2], bq[1], bq[0]};
            m_burst = 0;
          end
        end
        if (miss_valid && al(miss_addr) != m_addr) begin
          m_pend = 1; m_pend_addr = al(miss_addr);
        end
      end else if (m_pend) begin
        m_issue(m_pend_addr, 0); m_pend = 0;
      end else if (miss_valid) begin
        m_issue(al(miss_addr), 0);
      end else if (exec_valid && !exec_was_hit) begin
        m_issue(al(exec_line_addr) + 32'h10, 1);
      end
    end
  end

  task automatic check(input bit ok, input string what, input logic [127:0] got, input logic [127:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: %s got %h expected %h", phase, what, got, exp);
    end
  endtask

  // Compare on every cycle, away from the active edge.
  always @(negedge clk) begin
    if (!rst) begin
      if (mem_req) n_req++;
      if (fill_valid) n_fill++;
      check(mem_req === e_req, "mem_req", 128'(mem_req), 128'(e_req));
      if (e_req) check(mem_addr === e_addr, "mem_addr", 128'(mem_addr), 128'(e_addr));
      check(fill_valid === e_fill, "fill_valid", 128'(fill_valid), 128'(e_fill));
      if (e_fill) begin
        check(fill_addr === e_faddr, "fill_addr", 128'(fill_addr), 128'(e_faddr));
        check(fill_is_prefetch === e_fpref, "fill_is_prefetch", 128'(fill_is_prefetch), 128'(e_fpref));
        check(fill_data === e_fdata, "fill_data", fill_data, e_fdata);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      miss_valid = 0; exec_valid = 0; exec_was_hit = 0;
    end
  endtask

  task automatic pulse(input bit mv, input logic [31:0] ma, input bit ev, input logic [31:0] ea, input bit eh);
    @(negedge clk);
    miss_valid = mv; miss_addr = ma;
    exec_valid = ev; exec_line_addr = ea; exec_was_hit = eh;
  endtask

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 50000) begin
      n_bad++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  initial begin
    int r0, f0;
    repeat (4) @(negedge clk);
    rst = 0;
    phase = "R1 idle after reset";
    idle(4);

    phase = "R2 R3 demand miss fill";
    pulse(1, 32'h0000_1237, 0, 0, 0); idle(12);

    phase = "R4 prefetch after fresh line";
    pulse(0, 0, 1, 32'h0000_1234, 0); idle(12);

    phase = "R5 resident line no prefetch";
    r0 = n_req;
    pulse(0, 0, 1, 32'h0000_1240, 1); idle(6);
    check(n_req == r0, "R5 request count", 128'(n_req - r0), 0);

    phase = "R6 next line wraps";
    pulse(0, 0, 1, 32'hFFFF_FFF8, 0); idle(12);

    phase = "R7 miss waits behind prefetch";
    mem_lat = 3;
    pulse(0, 0, 1, 32'h0000_2000, 0); idle(2);
    pulse(1, 32'h0000_5004, 0, 0, 0); idle(25);

    phase = "R8 miss covered by prefetch";
    r0 = n_req; f0 = n_fill;
    pulse(0, 0, 1, 32'h0000_3000, 0); idle(1);
    pulse(1, 32'h0000_301C, 0, 0, 0); idle(20);
    check(n_req - r0 == 1, "R8 request count", 128'(n_req - r0), 1);
    check(n_fill - f0 == 1, "R8 fill count", 128'(n_fill - f0), 1);

    phase = "R9 trigger during burst dropped";
    r0 = n_req;
    pulse(0, 0, 1, 32'h0000_4000, 0); idle(2);
    pulse(0, 0, 1, 32'h0000_7000, 0); idle(20);
    check(n_req - r0 == 1, "R9 request count busy", 128'(n_req - r0), 1);
    phase = "R9 miss beats same-cycle trigger";
    r0 = n_req;
    pulse(1, 32'h0000_8000, 1, 32'h0000_9000, 0); idle(20);
    check(n_req - r0 == 1, "R9 request count priority", 128'(n_req - r0), 1);

    phase = "R11 stray beats ignored";
    f0 = n_fill;
    stray_en = 1; idle(6); stray_en = 0;
    check(n_fill == f0, "R11 fill count", 128'(n_fill - f0), 0);
    mem_lat = 0;
    pulse(1, 32'h0000_A008, 0, 0, 0); idle(10);

    phase = "R10 R7 mixed traffic";
    for (int i = 0; i < 60; i++) begin
      mem_lat = i % 3;
      pulse(i % 4 == 1, 32'h0001_0000 + 32'(i * 48), i % 3 != 2,
            32'h0002_0000 + 32'(i * 16), i % 5 == 0);
      idle(i % 7);
    end
    idle(30);
    finish_run();
  end

endmodule